// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block sits in the register-fetch stage of a five-stage pipeline (fetch, register fetch, ALU, memory, write-back). For one source operand it decides where the current value of the named register really lives. That value may be in an instruction still in flight in the ALU, memory or write-back stage, or in the register file read data. The block then delivers that value in the same cycle.

Each of the three downstream stages presents a destination register number, a flag that says whether the instruction writes a register, and its result. Branches and jumps deliver their saved return address (PC+4) instead of the ALU output. The block makes the return-address choice for the ALU stage. The memory stage supplies a value in which that choice is already folded. At write-back the block makes the final choice between that value and load data. Register 31 reads as zero and is never forwarded. A stage that does not write a register is treated as targeting register 31, so it can never match.

A processor instantiates the block twice. The operand A copy ties `use_alt` low. The operand B copy uses `use_alt` to pick between its two candidate register fields. A 3-bit code reports which source was chosen.

Top module: `operand_bypass_select`

## Requirements
- R1: When the effective source register is 31, `operand` is zero and `src_sel` is 4, even when a stage reports a write to register 31.
- R2: When the ALU-stage destination matches and that stage writes, `src_sel` is 1. `operand` is `alu_pc4` when `alu_link` is 1 and `alu_result` otherwise.
- R3: When the memory stage matches and writes, and the ALU stage does not match, `src_sel` is 2 and `operand` is `mem_y`.
- R4: When only the write-back stage matches and writes, `src_sel` is 3. `operand` is `wb_rdata` when `wb_load` is 1 and `wb_y` otherwise.
- R5: When no writing stage matches, `src_sel` is 0 and `operand` is `rf_data`.
- R6: When several stages match, the youngest one wins: ALU over memory, and memory over write-back.
- R7: A stage whose write flag is 0 never supplies the operand, even when its destination number equals the source.
- R8: The effective source register is `src_alt` when `use_alt` is 1 and `src_main` when it is 0.
- R9: The block holds no state. `operand` and `src_sel` follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_main | input | 5 | Primary source register number |
| src_alt | input | 5 | Alternate source register number |
| use_alt | input | 1 | Select the alternate source register |
| alu_dst | input | 5 | ALU-stage destination register |
| alu_wr | input | 1 | ALU-stage instruction writes a register |
| alu_link | input | 1 | ALU-stage instruction is a branch or jump |
| alu_result | input | 32 | ALU-stage computed result |
| alu_pc4 | input | 32 | ALU-stage saved return address |
| mem_dst | input | 5 | Memory-stage destination register |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_y | input | 32 | Memory-stage result (return address already folded in) |
| wb_dst | input | 5 | Write-back destination register |
| wb_wr | input | 1 | Write-back instruction writes a register |
| wb_load | input | 1 | Write-back instruction is a load |
| wb_y | input | 32 | Write-back ALU or return-address value |
| wb_rdata | input | 32 | Write-back memory read data |
| rf_data | input | 32 | Register file read data |
| operand | output | 32 | Selected operand value |
| src_sel | output | 3 | Source code: 0 file, 1 ALU, 2 memory, 3 write-back, 4 zero |

## Verification
The bench builds the block with its default parameters: 32-bit data and 5-bit register numbers, so the zero register is 31. These widths make register 31 the all-ones code. A stage that does not write then falls on the same tag as the zero register, and the bench can show that a non-writing stage and the zero register together never produce a forward. The directed cases cover every priority combination and both return-address and load choices. A randomized run then draws destinations from a narrow range that includes 31, which makes multi-stage matches frequent.

// File: rtl/operand_bypass_select.sv
module operand_bypass_select #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic [REG_W-1:0]  src_main,
  input  logic [REG_W-1:0]  src_alt,
  input  logic              use_alt,
  input  logic [REG_W-1:0]  alu_dst,
  input  logic              alu_wr,
  input  logic              alu_link,
  input  logic [DATA_W-1:0] alu_result,
  input  logic [DATA_W-1:0] alu_pc4,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic              mem_wr,
  input  logic [DATA_W-1:0] mem_y,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic              wb_wr,
  input  logic              wb_load,
  input  logic [DATA_W-1:0] wb_y,
  input  logic [DATA_W-1:0] wb_rdata,
  input  logic [DATA_W-1:0] rf_data,
  output logic [DATA_W-1:0] operand,
  output logic [2:0]        src_sel
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;
  localparam logic [2:0] SEL_RF   = 3'd0;
  localparam logic [2:0] SEL_ALU  = 3'd1;
  localparam logic [2:0] SEL_MEM  = 3'd2;
  localparam logic [2:0] SEL_WB   = 3'd3;
  localparam logic [2:0] SEL_ZERO = 3'd4;

  logic [REG_W-1:0] src;
  logic [REG_W-1:0] alu_tag, mem_tag, wb_tag;
  logic hit_alu, hit_mem, hit_wb, is_zero;
  logic [DATA_W-1:0] alu_fwd, wb_fwd;

  assign src     = use_alt ? src_alt : src_main;
  assign is_zero = (src == ZERO_REG);

  assign alu_tag = alu_wr ? alu_dst : ZERO_REG;
  assign mem_tag = mem_wr ? mem_dst : ZERO_REG;
  assign wb_tag  = wb_wr  ? wb_dst  : ZERO_REG;

  assign hit_alu = !is_zero && (alu_tag == src);
  assign hit_mem = !is_zero && (mem_tag == src);
  assign hit_wb  = !is_zero && (wb_tag  == src);

  assign alu_fwd = alu_link ? alu_pc4  : alu_result;
  assign wb_fwd  = wb_load  ? wb_rdata : wb_y;

  always_comb begin
    if (is_zero) begin
      src_sel = SEL_ZERO;
      operand = '0;
    end else if (hit_alu) begin
      src_sel = SEL_ALU;
      operand = alu_fwd;
    end else if (hit_mem) begin
      src_sel = SEL_MEM;
      operand = mem_y;
    end else if (hit_wb) begin
      src_sel = SEL_WB;
      operand = wb_fwd;
    end else begin
      src_sel = SEL_RF;
      operand = rf_data;
    end
  end
endmodule

module operand_bypass_select_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input logic [REG_W-1:0]  src_main,
  input logic [REG_W-1:0]  src_alt,
  input logic              use_alt,
  input logic [REG_W-1:0]  alu_dst,
  input logic              alu_wr,
  input logic [REG_W-1:0]  mem_dst,
  input logic              mem_wr,
  input logic [REG_W-1:0]  wb_dst,
  input logic              wb_wr,
  input logic [DATA_W-1:0] rf_data,
  input logic [DATA_W-1:0] mem_y,
  input logic [DATA_W-1:0] operand,
  input logic [2:0]        src_sel
);
  logic [REG_W-1:0] s;
  assign s = use_alt ? src_alt : src_main;

  always_comb begin
    if (&s)
      assert_zero_R1: assert (src_sel == 3'd4 && operand == '0)
        else $error("zero register not forced");
    if (!(&s) && alu_wr && alu_dst == s)
      assert_alu_first_R6: assert (src_sel == 3'd1)
        else $error("ALU match lost priority");
    if (src_sel == 3'd1)
      assert_alu_writes_R7: assert (alu_wr && alu_dst == s)
        else $error("ALU forward without a writing match");
    if (src_sel == 3'd2)
      assert_mem_value_R3: assert (mem_wr && mem_dst == s && operand == mem_y)
        else $error("memory forward mismatch");
    if (src_sel == 3'd3)
      assert_wb_writes_R7: assert (wb_wr && wb_dst == s)
        else $error("write-back forward without a writing match");
    if (src_sel == 3'd0)
      assert_rf_value_R5: assert (operand == rf_data)
        else $error("file path value mismatch");
    assert_code_range_R9: assert (src_sel <= 3'd4)
      else $error("select code out of range");
  end
endmodule

bind operand_bypass_select operand_bypass_select_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .src_main(src_main), .src_alt(src_alt), .use_alt(use_alt),
  .alu_dst(alu_dst), .alu_wr(alu_wr), .mem_dst(mem_dst), .mem_wr(mem_wr),
  .wb_dst(wb_dst), .wb_wr(wb_wr), .rf_data(rf_data), .mem_y(mem_y),
  .operand(operand), .src_sel(src_sel)
);

// File: tb/tb_operand_bypass_select.sv
`timescale 1ns/1ps
module tb_operand_bypass_select;
  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic [4:0]  src_main, src_alt, alu_dst, mem_dst, wb_dst;
  logic        use_alt, alu_wr, alu_link, mem_wr, wb_wr, wb_load;
  logic [31:0] alu_result, alu_pc4, mem_y, wb_y, wb_rdata, rf_data, operand;
  logic [2:0]  src_sel;

  operand_bypass_select dut (
    .src_main(src_main), .src_alt(src_alt), .use_alt(use_alt),
    .alu_dst(alu_dst), .alu_wr(alu_wr), .alu_link(alu_link),
    .alu_result(alu_result), .alu_pc4(alu_pc4),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_y(mem_y),
    .wb_dst(wb_dst), .wb_wr(wb_wr), .wb_load(wb_load),
    .wb_y(wb_y), .wb_rdata(wb_rdata), .rf_data(rf_data),
    .operand(operand), .src_sel(src_sel)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [2:0]  q_sel[$];
  logic [31:0] q_val[$];
  string       q_tag[$];

  task automatic clear_inputs();
    src_main = 0; src_alt = 0; use_alt = 0;
    alu_dst = 0; alu_wr = 0; alu_link = 0; alu_result = 32'hA1A1_0001; alu_pc4 = 32'hA1A1_0004;
    mem_dst = 0; mem_wr = 0; mem_y = 32'hB2B2_0002;
    wb_dst = 0; wb_wr = 0; wb_load = 0; wb_y = 32'hC3C3_0003; wb_rdata = 32'hD4D4_0004;
    rf_data = 32'hE5E5_0005;
  endtask

  task automatic expect_now(input logic [2:0] s, input logic [31:0] v, input string tag);
    q_sel.push_back(s); q_val.push_back(v); q_tag.push_back(tag);
    @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (q_sel.size() > 0) begin
      logic [2:0] es; logic [31:0] ev; string t;
      es = q_sel.pop_front(); ev = q_val.pop_front(); t = q_tag.pop_front();
      checks++;
      if (src_sel !== es || operand !== ev) begin
        errors++;
        $display("FAIL %s: sel=%0d operand=%h expected sel=%0d operand=%h", t, src_sel, operand, es, ev);
      end
    end
  end

  function automatic void model(output logic [2:0] s, output logic [31:0] v);
    logic [4:0] r;
    r = use_alt ? src_alt : src_main;
    if (r == 5'd31) begin s = 4; v = 0; end
    else if (alu_wr && alu_dst == r) begin s = 1; v = alu_link ? alu_pc4 : alu_result; end
    else if (mem_wr && mem_dst == r) begin s = 2; v = mem_y; end
    else if (wb_wr && wb_dst == r) begin s = 3; v = wb_load ? wb_rdata : wb_y; end
    else begin s = 0; v = rf_data; end
  endfunction

  initial begin
    clear_inputs();
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(posedge clk);
    expect_now(0, 32'hE5E5_0005, "R5 reset state");

    src_main = 5; alu_dst = 5; alu_wr = 1;
    expect_now(1, 32'hA1A1_0001, "R2 alu result");
    alu_link = 1;
    expect_now(1, 32'hA1A1_0004, "R2 alu link pc4");

    clear_inputs(); src_main = 7; mem_dst = 7; mem_wr = 1;
    expect_now(2, 32'hB2B2_0002, "R3 mem forward");

    clear_inputs(); src_main = 9; wb_dst = 9; wb_wr = 1;
    expect_now(3, 32'hC3C3_0003, "R4 wb y");
    wb_load = 1;
    expect_now(3, 32'hD4D4_0004, "R4 wb load data");

    clear_inputs(); src_main = 4; alu_dst = 4; alu_wr = 1; mem_dst = 4; mem_wr = 1; wb_dst = 4; wb_wr = 1;
    expect_now(1, 32'hA1A1_0001, "R6 alu over mem and wb");
    alu_wr = 0;
    expect_now(2, 32'hB2B2_0002, "R6 mem over wb (R7 alu not writing)");

    clear_inputs(); src_main = 31; alu_dst = 31; alu_wr = 1; mem_dst = 31; mem_wr = 1; wb_dst = 31; wb_wr = 1;
    expect_now(4, 0, "R1 zero register forced");

    clear_inputs(); src_main = 6; alu_dst = 6; mem_dst = 6; wb_dst = 6;
    expect_now(0, 32'hE5E5_0005, "R7 non-writing stages ignored");

    clear_inputs(); src_main = 2; src_alt = 3; use_alt = 1; mem_dst = 3; mem_wr = 1; wb_dst = 2; wb_wr = 1;
    expect_now(2, 32'hB2B2_0002, "R8 alternate source used");
    use_alt = 0;
    expect_now(3, 32'hC3C3_0003, "R8 main source used");
    src_alt = 31; use_alt = 1;
    expect_now(4, 0, "R1 R8 alternate zero register");

    clear_inputs(); src_main = 12; rf_data = 32'h1234_5678; wb_dst = 13; wb_wr = 1;
    expect_now(0, 32'h1234_5678, "R5 no match");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] es; logic [31:0] ev;
      src_main = ($urandom % 5 == 0) ? 5'd31 : 5'($urandom % 4);
      src_alt  = ($urandom % 5 == 0) ? 5'd31 : 5'($urandom % 4);
      use_alt = 1'($urandom); alu_link = 1'($urandom); wb_load = 1'($urandom);
      alu_dst = ($urandom % 6 == 0) ? 5'd31 : 5'($urandom % 4); alu_wr = 1'($urandom);
      mem_dst = ($urandom % 6 == 0) ? 5'd31 : 5'($urandom % 4); mem_wr = 1'($urandom);
      wb_dst  = ($urandom % 6 == 0) ? 5'd31 : 5'($urandom % 4); wb_wr  = 1'($urandom);
      alu_result = $urandom; alu_pc4 = $urandom; mem_y = $urandom;
      wb_y = $urandom; wb_rdata = $urandom; rf_data = $urandom;
      model(es, ev);
      expect_now(es, ev, "R9 random same-cycle R6 priority");
    end

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule